// File: doc/BRIEF.md
# Prioritized CPU Interrupt Controller

This block gathers sixteen interrupt request lines and offers a processor core the single most urgent pending request. It reports that request as a level number and a valid flag. Level 0 is the reset request and level 1 is the non-maskable interrupt. Levels 2 and 3 are reserved, and the block ignores them completely. Levels 4 to 15 serve sources outside the core. Among those, a lower level number is more urgent.

A rising edge on a request line sets a sticky pending flag. The core clears a flag by pulsing an acknowledge with the level number it has taken. Software can clear pending flags through a mask. It can also set pending flags on external levels, so the block can be tested without its real sources.

Each external level has an enable bit, and a global enable gates all of them. Reset and NMI bypass both the enable bits and the global enable. The level and valid outputs are registered. They describe the state left by the same clock edge that updates the flags and enables.

Top module: `prio_intc`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, every pending flag, every enable bit and the global enable are clear, `valid_o` is 0 and `lvl_o` is 0.
- R2: A request line of level 0, 1 or 4–15 that is low in one cycle and high in the next sets that level's pending flag. A line already high when reset is released counts as a rising edge. A line held high does not set its flag again once the flag has been cleared.
- R3: Levels 2 and 3 are never made pending and are never reported, whatever their request lines, the software set mask or the enables do.
- R4: `lvl_o` is the lowest-numbered level that is pending and eligible. Level 0 therefore outranks level 1, level 1 outranks every external level, and level 4 outranks level 15.
- R5: Levels 0 and 1 are eligible whenever they are pending, whatever the enable bits and the global enable hold.
- R6: External level n (4–15) is eligible only while enable bit `en_i[n-4]` (loaded when `en_wr_i` is 1) and the global enable (loaded from `gie_i` when `gie_wr_i` is 1) are both set. A masked level stays pending, and it is reported once it is unmasked.
- R7: The outputs are registered. A change to the request lines, the acknowledge, the software masks or the enable writes shows on `lvl_o`/`valid_o` one clock edge after the change is sampled.
- R8: A cycle with `ack_i` = 1 clears the pending flag of level `ack_lvl_i`. Acknowledging a level that is not pending changes nothing.
- R9: If a rising edge on a level arrives in the same cycle as an acknowledge or software clear of that level, the flag stays set.
- R10: For each bit n of `sw_set_i` that is 1, the pending flag of level n is set if n is 4–15. Bits 0–3 of `sw_set_i` are ignored.
- R11: For each bit n of `sw_clr_i` that is 1, the pending flag of level n is cleared.
- R12: Whenever `valid_o` is 0, `lvl_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 16 | Request lines, bit n is level n |
| sw_set_i | input | 16 | Software set mask, bit n sets level n (4–15 only) |
| sw_clr_i | input | 16 | Software clear mask, bit n clears level n |
| en_wr_i | input | 1 | Load the enable bits from `en_i` |
| en_i | input | 12 | Enable bits, bit j is level j+4 |
| gie_wr_i | input | 1 | Load the global enable from `gie_i` |
| gie_i | input | 1 | Global enable value |
| ack_i | input | 1 | Acknowledge pulse |
| ack_lvl_i | input | 4 | Level that is acknowledged |
| lvl_o | output | 4 | Winning level number |
| valid_o | output | 1 | A pending, eligible request exists |

## Verification
The hardest case to reach from the ports is a clear that meets a new edge on the same level in the same cycle. To get there, the bench must first drop the line, then raise it again in exactly the cycle it acknowledges or software-clears that level. Directed steps build this case for both the acknowledge and the software clear. They also build a held-high line that must not set its flag again after an acknowledge. A long seeded random run then mixes edges, enable writes and acknowledges that follow the reported level. A bench model predicts every output cycle by cycle, so collisions and masked pending levels also occur in many other combinations.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int unsigned NUM_LVL   = 16;
    localparam int unsigned FIRST_EXT = 4;
    localparam int unsigned LVL_W     = $clog2(NUM_LVL);
    localparam int unsigned NUM_EXT   = NUM_LVL - FIRST_EXT;

    typedef logic [NUM_LVL-1:0] lvl_vec_t;
endpackage

// File: rtl/intc_pending.sv
module intc_pending
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  lvl_vec_t         irq_i,
    input  lvl_vec_t         sw_set_i,
    input  lvl_vec_t         sw_clr_i,
    input  logic             ack_i,
    input  logic [LVL_W-1:0] ack_lvl_i,
    output lvl_vec_t         pend_d_o,
    output lvl_vec_t         pend_q_o
);
    typedef struct packed {
        lvl_vec_t irq_prev;
        lvl_vec_t pend;
    } pend_st_t;

    pend_st_t st_d, st_q;
    lvl_vec_t hw_ok;
    lvl_vec_t sw_ok;
    lvl_vec_t rise;
    lvl_vec_t set_v;
    lvl_vec_t clr_v;

    // which levels accept hardware edges and software sets
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl_mask
        assign hw_ok[g] = (g < 2) || (g >= FIRST_EXT);
        assign sw_ok[g] = (g >= FIRST_EXT);
    end

    always_comb begin
        st_d  = st_q;
        rise  = irq_i & ~st_q.irq_prev & hw_ok;
        set_v = rise | (sw_set_i & sw_ok);
        clr_v = sw_clr_i;
        if (ack_i) begin
            clr_v[ack_lvl_i] = 1'b1;
        end
        st_d.irq_prev = irq_i;
        // a fresh edge outranks a clear in the same cycle
        st_d.pend     = (st_q.pend & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_d_o = st_d.pend;
    assign pend_q_o = st_q.pend;

    AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((st_q.pend & $past(rise)) == $past(rise))); // R2

    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !set_v[ack_lvl_i]) |=> !st_q.pend[$past(ack_lvl_i)]); // R8

    AST_RSV_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend & ~(hw_ok | sw_ok)) == '0); // R3
endmodule

// File: rtl/intc_pick.sv
module intc_pick
    import intc_pkg::*;
(
    input  lvl_vec_t         req_i,
    output logic             valid_o,
    output logic [LVL_W-1:0] lvl_o
);
    always_comb begin
        valid_o = 1'b0;
        lvl_o   = '0;
        // scan from least to most urgent so the lowest index is kept
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                valid_o = 1'b1;
                lvl_o   = LVL_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LVL-1:0]   irq_i,
    input  logic [NUM_LVL-1:0]   sw_set_i,
    input  logic [NUM_LVL-1:0]   sw_clr_i,
    input  logic                 en_wr_i,
    input  logic [NUM_EXT-1:0]   en_i,
    input  logic                 gie_wr_i,
    input  logic                 gie_i,
    input  logic                 ack_i,
    input  logic [LVL_W-1:0]     ack_lvl_i,
    output logic [LVL_W-1:0]     lvl_o,
    output logic                 valid_o
);
    typedef struct packed {
        logic [NUM_EXT-1:0] en;
        logic               gie;
        logic [LVL_W-1:0]   lvl;
        logic               valid;
    } top_st_t;

    top_st_t          st_d, st_q;
    lvl_vec_t         pend_d;
    lvl_vec_t         pend_q;
    lvl_vec_t         gate;
    logic             pick_valid;
    logic [LVL_W-1:0] pick_lvl;

    intc_pending u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_i     (irq_i),
        .sw_set_i  (sw_set_i),
        .sw_clr_i  (sw_clr_i),
        .ack_i     (ack_i),
        .ack_lvl_i (ack_lvl_i),
        .pend_d_o  (pend_d),
        .pend_q_o  (pend_q)
    );

    // eligibility per level, computed from the enables being written now
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_gate
        if (g < 2) begin : g_fixed
            assign gate[g] = 1'b1;
        end else if (g < FIRST_EXT) begin : g_rsv
            assign gate[g] = 1'b0;
        end else begin : g_ext
            assign gate[g] = st_d.en[g-FIRST_EXT] & st_d.gie;
        end
    end

    intc_pick u_pick (
        .req_i   (pend_d & gate),
        .valid_o (pick_valid),
        .lvl_o   (pick_lvl)
    );

    always_comb begin
        st_d = st_q;
        if (en_wr_i) begin
            st_d.en = en_i;
        end
        if (gie_wr_i) begin
            st_d.gie = gie_i;
        end
        st_d.lvl   = pick_lvl;
        st_d.valid = pick_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o   = st_q.lvl;
    assign valid_o = st_q.valid;

    AST_RSV_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((lvl_o < 2) || (lvl_o >= LVL_W'(FIRST_EXT)))); // R3

    AST_RST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[0] |-> (valid_o && lvl_o == '0)); // R4

    AST_NMI_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[1] |-> valid_o); // R5

    AST_GIE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && lvl_o >= LVL_W'(FIRST_EXT)) |-> st_q.gie); // R6

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (lvl_o == '0)); // R12
endmodule

// File: tb/prio_intc_tb_top.sv
`timescale 1ns/1ps
module prio_intc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq = '0, sws = '0, swc = '0;
    logic        en_wr = 1'b0, gie_wr = 1'b0, gie_v = 1'b0, ack = 1'b0;
    logic [11:0] en_v = '0;
    logic [3:0]  ackl = '0;
    logic [3:0]  lvl;
    logic        valid;

    logic [15:0] m_pend, m_prev;
    logic [11:0] m_en;
    logic        m_gie;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    prio_intc dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .sw_set_i(sws), .sw_clr_i(swc),
        .en_wr_i(en_wr), .en_i(en_v), .gie_wr_i(gie_wr), .gie_i(gie_v),
        .ack_i(ack), .ack_lvl_i(ackl), .lvl_o(lvl), .valid_o(valid)
    );

    // expected {valid, level} from the model state
    function automatic logic [4:0] exp_out(logic [15:0] p, logic [11:0] e, logic g);
        logic [15:0] elig;
        elig = p & {e & {12{g}}, 2'b00, 2'b11};
        for (int i = 0; i < 16; i++) begin
            if (elig[i]) return {1'b1, 4'(i)};
        end
        return 5'd0;
    endfunction

    task automatic model_step();
        logic [15:0] set_v, clr_v;
        set_v = (irq & ~m_prev & 16'hFFF3) | (sws & 16'hFFF0);
        clr_v = swc;
        if (ack) clr_v[ackl] = 1'b1;
        m_pend = (m_pend & ~clr_v) | set_v;
        m_prev = irq;
        if (en_wr) m_en = en_v;
        if (gie_wr) m_gie = gie_v;
    endtask

    task automatic expect_out(string tag, logic ev, logic [3:0] el);
        checks++;
        if (valid !== ev || lvl !== el) begin
            errors++;
            $display("FAIL %s: valid/lvl actual %0b/%0d expected %0b/%0d", tag, valid, lvl, ev, el);
        end
    endtask

    // one cycle: inputs already driven; compare to model after the edge
    task automatic tick(string tag);
        logic [4:0] e;
        model_step();
        @(posedge clk);
        @(negedge clk);
        e = exp_out(m_pend, m_en, m_gie);
        expect_out(tag, e[4], e[3:0]);
        sws = '0; swc = '0; en_wr = 1'b0; gie_wr = 1'b0; ack = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_pend = '0; m_prev = '0; m_en = '0; m_gie = 1'b0;
        irq = 16'h0022;
        repeat (3) @(negedge clk);
        expect_out("R1 in reset", 1'b0, 4'd0);
        rst_n = 1'b1;
        irq = '0;
        tick("R1 after release");
        expect_out("R1 idle", 1'b0, 4'd0);

        // R3: reserved lines and software set of reserved bits
        en_v = 12'hFFF; en_wr = 1'b1; gie_v = 1'b1; gie_wr = 1'b1;
        irq = 16'h000C; sws = 16'h000C;
        tick("R3 reserved ignored");
        expect_out("R3 reserved", 1'b0, 4'd0);
        irq = '0; tick("R3 drop");

        // R6: masked external level stays pending
        en_v = 12'h000; en_wr = 1'b1;
        irq[5] = 1'b1;
        tick("R6 masked");
        expect_out("R6 masked level5", 1'b0, 4'd0);
        en_v = 12'h002; en_wr = 1'b1;
        tick("R7 enable visible next edge");
        expect_out("R6 unmasked level5", 1'b1, 4'd5);
        gie_v = 1'b0; gie_wr = 1'b1;
        tick("R6 gie off");
        expect_out("R6 gie off", 1'b0, 4'd0);

        // R5: NMI and reset ignore masks; R4 order
        irq[1] = 1'b1;
        tick("R5 nmi");
        expect_out("R5 nmi unmasked", 1'b1, 4'd1);
        irq[0] = 1'b1;
        tick("R4 reset first");
        expect_out("R4 reset over nmi", 1'b1, 4'd0);
        ack = 1'b1; ackl = 4'd0;
        tick("R8 ack reset");
        expect_out("R8 ack reset", 1'b1, 4'd1);
        ack = 1'b1; ackl = 4'd1;
        tick("R8 ack nmi");
        expect_out("R8 ack nmi", 1'b0, 4'd0);
        ack = 1'b1; ackl = 4'd9;
        tick("R8 ack not pending");
        gie_v = 1'b1; gie_wr = 1'b1;
        tick("R6 gie on");
        expect_out("R6 level5 still pending", 1'b1, 4'd5);

        // R9: edge and ack together on level 5
        irq[5] = 1'b0; tick("R9 drop");
        irq[5] = 1'b1; ack = 1'b1; ackl = 4'd5;
        tick("R9 edge beats ack");
        expect_out("R9 edge beats ack", 1'b1, 4'd5);
        // R2: held-high line does not set again
        ack = 1'b1; ackl = 4'd5;
        tick("R2 held high");
        expect_out("R2 no re-edge", 1'b0, 4'd0);

        // R10 / R11
        en_v = 12'hFFF; en_wr = 1'b1;
        sws = 16'h0003;
        tick("R10 low bits ignored");
        expect_out("R10 low bits ignored", 1'b0, 4'd0);
        sws = 16'h8000;
        tick("R10 sw set 15");
        expect_out("R10 sw set 15", 1'b1, 4'd15);
        sws = 16'h0010;
        tick("R4 level4 over 15");
        expect_out("R4 level4 over 15", 1'b1, 4'd4);
        swc = 16'h0010;
        tick("R11 clear 4");
        expect_out("R11 clear 4", 1'b1, 4'd15);
        irq[15] = 1'b1; swc = 16'h8000;
        tick("R9 edge beats sw clear");
        expect_out("R9 edge beats sw clear", 1'b1, 4'd15);
        swc = 16'h8000;
        tick("R11 clear 15");
        expect_out("R11 clear 15", 1'b0, 4'd0);

        // R4 random mix against the model
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            for (int b = 0; b < 16; b++) begin
                if ($urandom_range(0, 15) == 0) irq[b] = ~irq[b];
            end
            if ($urandom_range(0, 31) == 0) begin en_wr = 1'b1; en_v = 12'($urandom); end
            if ($urandom_range(0, 31) == 0) begin gie_wr = 1'b1; gie_v = ($urandom_range(0, 3) != 0); end
            if ($urandom_range(0, 3) == 0) begin
                ack = 1'b1;
                ackl = ($urandom_range(0, 1) == 0) ? lvl : 4'($urandom);
            end
            if ($urandom_range(0, 15) == 0) sws = 16'($urandom);
            if ($urandom_range(0, 15) == 0) swc = 16'($urandom);
            tick("R4 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule